// File: doc/BRIEF.md
# Dual Quad-SPI Flash Lane Router

This block sits between a quad-SPI transfer engine that only knows how to talk to one flash device and two physical flash ports. Each port has its own chip select, serial clock and 4-bit IO bus. The engine provides one active-low chip select, a serial clock, a transmit byte, a drive-direction flag and a flag that marks the data phase. The router turns that one-device view into one of three wirings, chosen by a configuration word.

In single mode only the lower port works, and the upper port stays idle. In stacked mode both devices share the bus wiring, and a page bit chooses which device gets the chip select, so only one device is addressed at a time. In parallel mode both devices are selected together. During the data phase each byte is split bit by bit: even bits go to the lower device and odd bits go to the upper device, so one byte moves per clock. Read nibbles are merged back into a byte in the same order. Command and address phases are sent identically to both buses.

Configuration words only take effect while the engine's chip select is high. A word written during a transfer is held and applied once the transfer ends. The routing itself is combinational from the applied configuration and the engine signals.

Top module: `qspi_dual_router`

## Requirements
- R1: After reset the applied configuration is single mode, and while the engine chip select is high (idle) both port chip selects are high.
- R2: In single mode, lower chip select, clock and IO out equal the engine's chip select, clock and tx[3:0]. Each lower output enable equals the engine drive flag. The upper port holds chip select high, clock low, IO out 0 and output enables 0. Read data is {4'b0, lower IO in}.
- R3: Configuration word bit 30 enables dual operation, bit 29 (with bit 30) selects parallel, and bit 28 selects the upper device in stacked mode. With bit 30 clear the mode is single whatever bits 29 and 28 hold.
- R4: In stacked mode (bit 30 set, bit 29 clear), the engine chip select goes to the upper port when bit 28 is set and to the lower port when bit 28 is clear. The other port's chip select stays high, so both are never low together.
- R5: In stacked mode both ports get the engine clock, tx[3:0] and the drive flag on every output enable. Read data is {4'b0, IO in of the selected port}.
- R6: In parallel mode (bits 30 and 29 set), both port chip selects follow the engine chip select and both ports get the engine clock and the drive flag.
- R7: In parallel mode with the data-phase flag high, lower IO out bit k equals tx bit 2k and upper IO out bit k equals tx bit 2k+1, for k = 0 to 3.
- R8: In parallel mode with the data-phase flag high, read bit 2k equals lower IO in bit k and read bit 2k+1 equals upper IO in bit k.
- R9: In parallel mode with the data-phase flag low, both ports output tx[3:0] and read data is {4'b0, lower IO in}.
- R10: A configuration write sampled on a rising edge while the engine chip select is high is applied from that edge.
- R11: A configuration write sampled while the engine chip select is low leaves the applied mode unchanged for the rest of the transfer. It is applied on the first rising edge at which the chip select is high, and the latest such held write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word (bits 30, 29, 28 used) |
| eng_cs_n | input | 1 | Engine chip select, active low |
| eng_sclk | input | 1 | Engine serial clock |
| eng_oe | input | 1 | Engine drive flag, 1 = drive IO pins |
| eng_data_phase | input | 1 | High during the data phase of a transfer |
| eng_tx | input | 8 | Transmit byte; only [3:0] is used outside the parallel data phase |
| eng_rx | output | 8 | Read data back to the engine |
| lo_cs_n | output | 1 | Lower device chip select |
| lo_sclk | output | 1 | Lower device clock |
| lo_io_o | output | 4 | Lower IO output values |
| lo_io_oe | output | 4 | Lower IO output enables |
| lo_io_i | input | 4 | Lower IO input values |
| hi_cs_n | output | 1 | Upper device chip select |
| hi_sclk | output | 1 | Upper device clock |
| hi_io_o | output | 4 | Upper IO output values |
| hi_io_oe | output | 4 | Upper IO output enables |
| hi_io_i | input | 4 | Upper IO input values |

## Verification
The only state is the applied and pending configuration, so a wrong state shows up as the wrong mode on the very next port observation. In that case the wrong chip select drops, the upper port wakes or stays idle when it should not, or bits come out in the wrong lanes. A held write that leaks in early changes the chip selects inside the same transfer. A held write that is lost leaves the old routing visible as soon as the next transfer starts. Each scenario checks the ports in the cycle after the configuration edge and again across a chip-select boundary.

// File: rtl/qdr_pkg.sv
// Shared types for the dual quad-SPI lane router.
// Assumes a 2-bit mode encoding used only inside the block.
package qdr_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_STACK  = 2'd1,
        MODE_SPLIT  = 2'd2
    } mode_e;

    typedef struct packed {
        logic dual;
        logic split;
        logic upper;
    } cfg_t;

    // Map the decoded configuration fields to a routing mode.
    function automatic mode_e cfg_to_mode(input cfg_t c);
        if (!c.dual)
            return MODE_SINGLE;
        else if (c.split)
            return MODE_SPLIT;
        else
            return MODE_STACK;
    endfunction

endpackage

// File: rtl/qdr_cfg_hold.sv
// Configuration capture for the lane router.
// Applies a write at once when the engine chip select is high; otherwise holds
// it (latest wins) until the first edge with the chip select high.
// Assumes eng_cs_n changes away from the clock edge used to sample it.
module qdr_cfg_hold
    import qdr_pkg::*;
#(
    parameter int CFG_W     = 32,
    parameter int DUAL_BIT  = 30,
    parameter int SPLIT_BIT = 29,
    parameter int UPPER_BIT = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eng_cs_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output cfg_t             cfg_q
);

    cfg_t wr_fields;
    cfg_t pend_q;
    logic pend_vld_q;

    // Extract the three used fields from the incoming word.
    always_comb begin
        wr_fields.dual  = cfg_wdata[DUAL_BIT];
        wr_fields.split = cfg_wdata[SPLIT_BIT];
        wr_fields.upper = cfg_wdata[UPPER_BIT];
    end

    // Apply, hold or release configuration depending on transfer activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
        end else if (cfg_wr && eng_cs_n) begin
            cfg_q      <= wr_fields;
            pend_vld_q <= 1'b0;
        end else if (cfg_wr) begin
            pend_q     <= wr_fields;
            pend_vld_q <= 1'b1;
        end else if (pend_vld_q && eng_cs_n) begin
            cfg_q      <= pend_q;
            pend_vld_q <= 1'b0;
        end
    end

endmodule

// File: rtl/qdr_cs_fanout.sv
// Chip-select and clock fan-out for the lane router.
// Expands the engine's single chip select into two port selects by mode and
// page bit. Assumes chip selects are active low and idle high.
module qdr_cs_fanout
    import qdr_pkg::*;
(
    input  mode_e mode,
    input  logic  upper,
    input  logic  eng_cs_n,
    input  logic  eng_sclk,
    output logic  lo_cs_n,
    output logic  hi_cs_n,
    output logic  lo_sclk,
    output logic  hi_sclk
);

    // Steer the chip select to one or both ports.
    always_comb begin
        unique case (mode)
            MODE_STACK: begin
                lo_cs_n = upper ? 1'b1 : eng_cs_n;
                hi_cs_n = upper ? eng_cs_n : 1'b1;
            end
            MODE_SPLIT: begin
                lo_cs_n = eng_cs_n;
                hi_cs_n = eng_cs_n;
            end
            default: begin
                lo_cs_n = eng_cs_n;
                hi_cs_n = 1'b1;
            end
        endcase
    end

    // Forward the serial clock; the upper port is parked low in single mode.
    always_comb begin
        lo_sclk = eng_sclk;
        hi_sclk = (mode == MODE_SINGLE) ? 1'b0 : eng_sclk;
    end

endmodule

// File: rtl/qdr_lane_mux.sv
// IO lane routing for the lane router.
// Splits a transmit byte across two nibble buses in the parallel data phase
// and merges read nibbles back; otherwise forwards one nibble.
// Assumes NIB_W lanes per port and a byte of 2*NIB_W bits.
module qdr_lane_mux
    import qdr_pkg::*;
#(
    parameter int NIB_W = 4,
    localparam int BYTE_W = 2 * NIB_W
) (
    input  mode_e             mode,
    input  logic              upper,
    input  logic              data_phase,
    input  logic              eng_oe,
    input  logic [BYTE_W-1:0] eng_tx,
    output logic [BYTE_W-1:0] eng_rx,
    output logic [NIB_W-1:0]  lo_io_o,
    output logic [NIB_W-1:0]  lo_io_oe,
    input  logic [NIB_W-1:0]  lo_io_i,
    output logic [NIB_W-1:0]  hi_io_o,
    output logic [NIB_W-1:0]  hi_io_oe,
    input  logic [NIB_W-1:0]  hi_io_i
);

    logic split_data;
    logic hi_active;
    logic [NIB_W-1:0] sel_i;

    // Decode the lane-level controls once for all bits.
    always_comb begin
        split_data = (mode == MODE_SPLIT) && data_phase;
        hi_active  = (mode != MODE_SINGLE);
        sel_i      = ((mode == MODE_STACK) && upper) ? hi_io_i : lo_io_i;
    end

    for (genvar k = 0; k < NIB_W; k++) begin : g_lane
        // Pick the outgoing bit of lane k for each port.
        always_comb begin
            lo_io_o[k]  = split_data ? eng_tx[2*k]   : eng_tx[k];
            hi_io_o[k]  = split_data ? eng_tx[2*k+1] : (hi_active & eng_tx[k]);
            lo_io_oe[k] = eng_oe;
            hi_io_oe[k] = hi_active & eng_oe;
        end

        // Place the incoming bits of lane k into the read byte.
        always_comb begin
            if (split_data) begin
                eng_rx[2*k]   = lo_io_i[k];
                eng_rx[2*k+1] = hi_io_i[k];
            end else begin
                eng_rx[2*k]   = (2*k < NIB_W)   ? sel_i[(2*k) % NIB_W]   : 1'b0;
                eng_rx[2*k+1] = (2*k+1 < NIB_W) ? sel_i[(2*k+1) % NIB_W] : 1'b0;
            end
        end
    end

endmodule

// File: rtl/qspi_dual_router.sv
// Top of the dual quad-SPI lane router.
// Holds the configuration, expands the engine chip select and routes IO lanes
// for single, stacked and parallel wiring of two identical flash devices.
// Assumes the engine changes its pins away from the rising edge of clk.
module qspi_dual_router
    import qdr_pkg::*;
#(
    parameter int CFG_W     = 32,
    parameter int NIB_W     = 4,
    parameter int DUAL_BIT  = 30,
    parameter int SPLIT_BIT = 29,
    parameter int UPPER_BIT = 28,
    localparam int BYTE_W   = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              eng_cs_n,
    input  logic              eng_sclk,
    input  logic              eng_oe,
    input  logic              eng_data_phase,
    input  logic [BYTE_W-1:0] eng_tx,
    output logic [BYTE_W-1:0] eng_rx,
    output logic              lo_cs_n,
    output logic              lo_sclk,
    output logic [NIB_W-1:0]  lo_io_o,
    output logic [NIB_W-1:0]  lo_io_oe,
    input  logic [NIB_W-1:0]  lo_io_i,
    output logic              hi_cs_n,
    output logic              hi_sclk,
    output logic [NIB_W-1:0]  hi_io_o,
    output logic [NIB_W-1:0]  hi_io_oe,
    input  logic [NIB_W-1:0]  hi_io_i
);

    cfg_t  cfg_q;
    mode_e mode;

    qdr_cfg_hold #(
        .CFG_W(CFG_W), .DUAL_BIT(DUAL_BIT),
        .SPLIT_BIT(SPLIT_BIT), .UPPER_BIT(UPPER_BIT)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .eng_cs_n(eng_cs_n),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q)
    );

    // Turn the applied fields into a routing mode.
    always_comb mode = cfg_to_mode(cfg_q);

    qdr_cs_fanout u_cs (
        .mode(mode), .upper(cfg_q.upper),
        .eng_cs_n(eng_cs_n), .eng_sclk(eng_sclk),
        .lo_cs_n(lo_cs_n), .hi_cs_n(hi_cs_n),
        .lo_sclk(lo_sclk), .hi_sclk(hi_sclk)
    );

    qdr_lane_mux #(.NIB_W(NIB_W)) u_lane (
        .mode(mode), .upper(cfg_q.upper), .data_phase(eng_data_phase),
        .eng_oe(eng_oe), .eng_tx(eng_tx), .eng_rx(eng_rx),
        .lo_io_o(lo_io_o), .lo_io_oe(lo_io_oe), .lo_io_i(lo_io_i),
        .hi_io_o(hi_io_o), .hi_io_oe(hi_io_oe), .hi_io_i(hi_io_i)
    );

endmodule

// File: rtl/qdr_checker.sv
// Assertion checker for the lane router, bound into every instance.
// Observes ports plus the applied configuration and mode of the top.
module qdr_checker
    import qdr_pkg::*;
#(
    parameter int CFG_W     = 32,
    parameter int NIB_W     = 4,
    parameter int DUAL_BIT  = 30,
    parameter int SPLIT_BIT = 29,
    parameter int UPPER_BIT = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic             eng_cs_n,
    input cfg_t             cfg_q,
    input mode_e            mode,
    input logic             lo_cs_n,
    input logic             hi_cs_n,
    input logic             hi_sclk,
    input logic [NIB_W-1:0] hi_io_oe
);

    logic prev_apply;
    logic was_active;
    cfg_t prev_wr;
    cfg_t prev_cfg;

    // Remember last cycle's write and activity since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_apply <= 1'b0;
            was_active <= 1'b0;
            prev_wr    <= '0;
            prev_cfg   <= '0;
        end else begin
            prev_apply <= cfg_wr && eng_cs_n;
            was_active <= !eng_cs_n;
            prev_wr    <= '{dual: cfg_wdata[DUAL_BIT], split: cfg_wdata[SPLIT_BIT],
                            upper: cfg_wdata[UPPER_BIT]};
            prev_cfg   <= cfg_q;
        end
    end

    p_idle_cs_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cs_n |-> (lo_cs_n && hi_cs_n));

    p_single_upper_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SINGLE) |-> (hi_cs_n && !hi_sclk && hi_io_oe == '0));

    p_stack_one_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STACK) |-> (lo_cs_n || hi_cs_n));

    p_split_both_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SPLIT) |-> (lo_cs_n == hi_cs_n));

    p_apply_idle_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prev_apply |-> (cfg_q == prev_wr));

    p_hold_during_xfer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (was_active && !eng_cs_n) |-> (cfg_q == prev_cfg));

endmodule

bind qspi_dual_router qdr_checker #(
    .CFG_W(CFG_W), .NIB_W(NIB_W), .DUAL_BIT(DUAL_BIT),
    .SPLIT_BIT(SPLIT_BIT), .UPPER_BIT(UPPER_BIT)
) u_qdr_checker (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .eng_cs_n(eng_cs_n), .cfg_q(cfg_q), .mode(mode),
    .lo_cs_n(lo_cs_n), .hi_cs_n(hi_cs_n), .hi_sclk(hi_sclk), .hi_io_oe(hi_io_oe)
);

// File: tb/tb_qspi_dual_router.sv
// Directed bench for the dual quad-SPI lane router.
module tb_qspi_dual_router;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] W_SINGLE = 32'h0000_0000;
    localparam logic [31:0] W_STK_LO = 32'h4000_0000;
    localparam logic [31:0] W_STK_HI = 32'h5000_0000;
    localparam logic [31:0] W_SPLIT  = 32'h6000_0000;
    localparam logic [31:0] W_NODUAL = 32'h3000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic eng_cs_n = 1'b1;
    logic eng_sclk = 1'b0;
    logic eng_oe = 1'b0;
    logic eng_data_phase = 1'b0;
    logic [7:0] eng_tx = '0;
    logic [7:0] eng_rx;
    logic lo_cs_n, lo_sclk, hi_cs_n, hi_sclk;
    logic [3:0] lo_io_o, lo_io_oe, hi_io_o, hi_io_oe;
    logic [3:0] lo_io_i = '0;
    logic [3:0] hi_io_i = '0;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qspi_dual_router dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .eng_cs_n(eng_cs_n), .eng_sclk(eng_sclk), .eng_oe(eng_oe),
        .eng_data_phase(eng_data_phase), .eng_tx(eng_tx), .eng_rx(eng_rx),
        .lo_cs_n(lo_cs_n), .lo_sclk(lo_sclk), .lo_io_o(lo_io_o),
        .lo_io_oe(lo_io_oe), .lo_io_i(lo_io_i),
        .hi_cs_n(hi_cs_n), .hi_sclk(hi_sclk), .hi_io_o(hi_io_o),
        .hi_io_oe(hi_io_oe), .hi_io_i(hi_io_i)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive a configuration write for one edge, then settle away from the edge.
    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_wr = 1'b0;
        #1;
    endtask

    task automatic set_cs(input logic v);
        @(negedge clk);
        eng_cs_n = v;
        #1;
    endtask

    function automatic logic [7:0] pack_rd(input logic [3:0] lo, input logic [3:0] hi);
        logic [7:0] r;
        for (int k = 0; k < 4; k++) begin
            r[2*k] = lo[k];
            r[2*k+1] = hi[k];
        end
        return r;
    endfunction

    task automatic t_reset();
        check(lo_cs_n && hi_cs_n, "R1 idle selects", {lo_cs_n, hi_cs_n}, 2'b11);
        set_cs(1'b0);
        check(!lo_cs_n && hi_cs_n, "R1 reset mode single", {lo_cs_n, hi_cs_n}, 2'b01);
        set_cs(1'b1);
    endtask

    task automatic t_single();
        write_cfg(W_NODUAL);
        set_cs(1'b0);
        eng_sclk = 1'b1; eng_oe = 1'b1; eng_tx = 8'hA5;
        lo_io_i = 4'h9; hi_io_i = 4'h6;
        #1;
        check(!lo_cs_n && hi_cs_n, "R3 no dual bit means single", {lo_cs_n, hi_cs_n}, 2'b01);
        check(lo_sclk && lo_io_o == 4'h5 && lo_io_oe == 4'hF, "R2 lower forward",
              {lo_sclk, lo_io_o, lo_io_oe}, {1'b1, 4'h5, 4'hF});
        check(!hi_sclk && hi_io_o == 4'h0 && hi_io_oe == 4'h0, "R2 upper idle",
              {hi_sclk, hi_io_o, hi_io_oe}, 9'h0);
        check(eng_rx == 8'h09, "R2 read lower", eng_rx, 8'h09);
        eng_sclk = 1'b0; eng_oe = 1'b0;
        set_cs(1'b1);
    endtask

    task automatic t_stacked();
        write_cfg(W_STK_LO);
        check(lo_cs_n && hi_cs_n, "R10 idle after write", {lo_cs_n, hi_cs_n}, 2'b11);
        set_cs(1'b0);
        eng_sclk = 1'b1; eng_oe = 1'b1; eng_tx = 8'h3C;
        lo_io_i = 4'h2; hi_io_i = 4'hD;
        #1;
        check(!lo_cs_n && hi_cs_n, "R4 stacked lower select", {lo_cs_n, hi_cs_n}, 2'b01);
        check(lo_io_o == 4'hC && hi_io_o == 4'hC && hi_sclk && hi_io_oe == 4'hF,
              "R5 shared bus", {hi_sclk, lo_io_o, hi_io_o, hi_io_oe}, {1'b1, 12'hCCF});
        check(eng_rx == 8'h02, "R5 read lower", eng_rx, 8'h02);
        set_cs(1'b1);
        write_cfg(W_STK_HI);
        set_cs(1'b0);
        check(lo_cs_n && !hi_cs_n, "R4 stacked upper select", {lo_cs_n, hi_cs_n}, 2'b10);
        check(eng_rx == 8'h0D, "R5 read upper", eng_rx, 8'h0D);
        eng_sclk = 1'b0; eng_oe = 1'b0;
        set_cs(1'b1);
    endtask

    task automatic t_parallel();
        logic [7:0] pats [3] = '{8'hCA, 8'h55, 8'hFF};
        write_cfg(W_SPLIT);
        set_cs(1'b0);
        eng_sclk = 1'b1; eng_oe = 1'b1;
        #1;
        check(!lo_cs_n && !hi_cs_n && hi_sclk && hi_io_oe == 4'hF, "R6 both selected",
              {lo_cs_n, hi_cs_n, hi_sclk, hi_io_oe}, {3'b001, 4'hF});
        eng_data_phase = 1'b0; eng_tx = 8'h3C; lo_io_i = 4'h7; hi_io_i = 4'h1;
        #1;
        check(lo_io_o == 4'hC && hi_io_o == 4'hC, "R9 command duplicated",
              {lo_io_o, hi_io_o}, 8'hCC);
        check(eng_rx == 8'h07, "R9 read lower only", eng_rx, 8'h07);
        eng_data_phase = 1'b1;
        foreach (pats[i]) begin
            logic [3:0] elo, ehi;
            for (int k = 0; k < 4; k++) begin
                elo[k] = pats[i][2*k];
                ehi[k] = pats[i][2*k+1];
            end
            eng_tx = pats[i];
            lo_io_i = ~elo; hi_io_i = ehi ^ 4'h5;
            #1;
            check(lo_io_o == elo && hi_io_o == ehi, "R7 byte split",
                  {lo_io_o, hi_io_o}, {elo, ehi});
            check(eng_rx == pack_rd(~elo, ehi ^ 4'h5), "R8 byte merge", eng_rx,
                  pack_rd(~elo, ehi ^ 4'h5));
        end
        eng_data_phase = 1'b0; eng_sclk = 1'b0; eng_oe = 1'b0;
        set_cs(1'b1);
    endtask

    task automatic t_held_write();
        write_cfg(W_SINGLE);
        set_cs(1'b0);
        write_cfg(W_SPLIT);
        check(!lo_cs_n && hi_cs_n, "R11 held write not applied", {lo_cs_n, hi_cs_n}, 2'b01);
        write_cfg(W_STK_HI);
        repeat (2) @(negedge clk);
        #1;
        check(!lo_cs_n && hi_cs_n && hi_io_oe == 4'h0, "R11 still single in transfer",
              {lo_cs_n, hi_cs_n, hi_io_oe}, 6'b010000);
        set_cs(1'b1);
        set_cs(1'b0);
        check(lo_cs_n && !hi_cs_n, "R11 latest held write applied", {lo_cs_n, hi_cs_n}, 2'b10);
        set_cs(1'b1);
        write_cfg(W_SINGLE);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_single();
        t_stacked();
        t_parallel();
        t_held_write();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule